// File: doc/BRIEF.md
# SPI Receive Word Queue with Threshold Interrupt

This block buffers words arriving from an SPI receive shifter until the CPU reads them. The shift side offers one word per cycle through a valid strobe. The CPU side issues read requests, and each one returns the oldest stored word. The queue holds up to four words. It reports its fill level as a 5-bit count and keeps a sticky flag that records that a word was dropped.

A control write loads three configured fields in one cycle: a run bit, an interrupt enable and a 5-bit threshold. The same write can carry two write-one clear pulses, one for the drop flag and one for the interrupt flag. Clearing the run bit empties the queue and holds it empty. The interrupt flag sets whenever the fill count is at or above the threshold. The interrupt line follows that flag, masked by the enable. The threshold resets to 31, a value the count can never reach, so no interrupt is raised until software lowers it.

Top module: `spi_rxq_top`

## Requirements
- R1: `occupancy` is the number of stored words in binary, from 0 to 4. An accepted word adds one and an accepted read takes one, both at the clock edge. Words are returned in arrival order.
- R2: A word that arrives while four words are stored and no read is accepted in that cycle drops the oldest word. `occupancy` stays at 4 and `ovf_flag` reads 1 after that edge.
- R3: `ovf_flag` stays set until a control write with `ctl_ovf_clr`=1. A control write with `ctl_ovf_clr`=0 leaves it unchanged. If a drop happens at the same edge as the clear, the flag stays 1.
- R4: While the stored run bit is 0, the queue is emptied at each edge, new words are ignored and reads return nothing new. After a control write with `ctl_run`=1, operation resumes from empty.
- R5: `int_flag` becomes 1 after any edge at which `occupancy` >= `cfg_level` (unsigned 5-bit compare). It clears only through a control write with `ctl_int_clr`=1. If the condition still holds at that edge, the flag stays 1.
- R6: `irq` equals `int_flag` while `cfg_int_en` is 1 and is 0 otherwise. The enable has no effect on `int_flag` itself.
- R7: After reset, `cfg_level`=5'b11111, `cfg_int_en`=0, `cfg_run`=1, `occupancy`=0, both flags are 0, `irq`=0 and `rd_word`=0. With the reset threshold, filling the queue raises no interrupt.
- R8: A word arriving in the same cycle as an accepted read on a full queue is not a drop. `occupancy` stays 4 and `ovf_flag` does not change.
- R9: A read request with `occupancy`=0 is ignored. `rd_word` keeps its last value and `occupancy` stays 0.
- R10: `rd_word` is a register. It takes the oldest word at the edge where a read is accepted and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sh_valid | input | 1 | Word offered by the shifter this cycle |
| sh_word | input | 16 | Received word |
| rd_req | input | 1 | CPU read request |
| rd_word | output | 16 | Last word read |
| ctl_we | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit to store (0 holds the queue empty) |
| ctl_int_en | input | 1 | Interrupt enable to store |
| ctl_level | input | 5 | Interrupt threshold to store |
| ctl_ovf_clr | input | 1 | Write-one clear for the drop flag |
| ctl_int_clr | input | 1 | Write-one clear for the interrupt flag |
| cfg_run | output | 1 | Stored run bit |
| cfg_int_en | output | 1 | Stored interrupt enable |
| cfg_level | output | 5 | Stored threshold |
| occupancy | output | 5 | Number of stored words |
| ovf_flag | output | 1 | Sticky drop flag |
| int_flag | output | 1 | Sticky threshold flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check every cycle that the count never passes four, and that the write pointer always sits exactly `occupancy` slots past the read pointer. They also check that a held queue is empty one edge later, that a drop or a read-and-write on a full queue leaves the count at four, that both flags stay set without a clear, and that a set wins over a clear at the same edge. The bench's scenarios show the facts that need a history of words: which word is lost on a drop, the order in which words come back, the data returned across drops, holds and empty reads, and the reset values of the configured fields. A reference model fed by random mixes of pushes, reads and control writes covers all of these.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Kind of queue update performed at one clock edge.
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_BOTH,
    OP_OVERRUN,
    OP_HOLD
  } rxq_op_e;

  // Next slot index in a ring of 'depth' slots.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Fill count after an update of the given kind.
  function automatic int unsigned occ_next(input int unsigned c, input rxq_op_e op);
    case (op)
      OP_PUSH: return c + 1;
      OP_POP:  return c - 1;
      OP_HOLD: return 0;
      default: return c;
    endcase
  endfunction

  // Threshold comparison used by the interrupt flag.
  function automatic bit at_or_above(input int unsigned c, input int unsigned lvl);
    return c >= lvl;
  endfunction

endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl #(
  parameter int CNT_W   = 5,
  parameter bit RUN_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             wr_run,
  input  logic             wr_int_en,
  input  logic [CNT_W-1:0] wr_level,
  input  logic             wr_ovf_clr,
  input  logic             wr_int_clr,
  output logic             run_q,
  output logic             int_en_q,
  output logic [CNT_W-1:0] level_q,
  output logic             ovf_clr,
  output logic             int_clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= RUN_RST;
      int_en_q <= 1'b0;
      level_q  <= '1;
    end else if (we) begin
      run_q    <= wr_run;
      int_en_q <= wr_int_en;
      level_q  <= wr_level;
    end
  end

  // Clear bits are not stored: they act only in the cycle of the write.
  assign ovf_clr = we & wr_ovf_clr;
  assign int_clr = we & wr_int_clr;

endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 5,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             push,
  input  logic             pop,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             wr_en,
  output logic             rd_take,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             pop_ok, full, rd_adv;
  rxq_op_e          op;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return PW'(wrap_inc(32'(p), DEPTH));
  endfunction

  always_comb begin
    pop_ok = pop && (count_q != '0);
    full   = (count_q == FULL);
    if (!run)                op = OP_HOLD;
    else if (push && pop_ok) op = OP_BOTH;
    else if (push)           op = full ? OP_OVERRUN : OP_PUSH;
    else if (pop_ok)         op = OP_POP;
    else                     op = OP_IDLE;
  end

  assign wr_en   = (op == OP_PUSH) || (op == OP_BOTH) || (op == OP_OVERRUN);
  assign rd_take = (op == OP_POP) || (op == OP_BOTH);
  assign rd_adv  = rd_take || (op == OP_OVERRUN);
  assign overrun = (op == OP_OVERRUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (op == OP_HOLD) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en)  wr_ptr_q <= step(wr_ptr_q);
      if (rd_adv) rd_ptr_q <= step(rd_ptr_q);
      count_q <= CNT_W'(occ_next(32'(count_q), op));
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
  assign count  = count_q;

  // R1: count bounded, pointers separated by exactly the count
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL);
  a_r1_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr_q == PW'((32'(rd_ptr_q) + 32'(count_q)) % DEPTH));
  // R2: a drop leaves the queue full
  a_r2_overrun_full: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> count_q == FULL);
  // R4: a held queue is empty at the next edge
  a_r4_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_q == '0) && (wr_ptr_q == '0) && (rd_ptr_q == '0));
  // R8: read and write together on a full queue keep it full
  a_r8_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && push && pop && full) |=> count_q == FULL);
  // R9: reading an empty queue changes nothing
  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pop && !push && count_q == '0) |=> count_q == '0);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_ptr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_take,
  input  logic [PW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] slot [DEPTH];
  logic [DW-1:0] rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot[g] <= '0;
      else if (wr_en && (wr_ptr == PW'(g)))    slot[g] <= wr_data;
    end
  end

  // The read register samples the slot before any write at the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_take) rd_q <= slot[rd_ptr];
  end

  assign rd_data = rd_q;

  // R10: the read register moves only on an accepted read
  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> $stable(rd_q));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] level,
  input  logic             overrun,
  input  logic             ovf_clr,
  input  logic             int_clr,
  input  logic             int_en,
  output logic             ovf_flag,
  output logic             int_flag,
  output logic             irq
);

  logic ovf_q, int_q, hit;

  assign hit = at_or_above(32'(count), 32'(level));

  // Set wins over clear for both flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      ovf_q <= overrun ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
      int_q <= hit     ? 1'b1 : (int_clr ? 1'b0 : int_q);
    end
  end

  assign ovf_flag = ovf_q;
  assign int_flag = int_q;
  assign irq      = int_q & int_en;

  // R2: a drop raises the flag
  a_r2_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> ovf_q);
  // R3: sticky without a clear
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R5: sticky, and a clear loses to a live condition
  a_r5_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q && !int_clr) |=> int_q);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && count >= level) |=> int_q);

endmodule

// File: rtl/spi_rxq_top.sv
module spi_rxq_top #(
  parameter int DEPTH   = 4,
  parameter int DW      = 16,
  parameter int CNT_W   = 5,
  parameter bit RUN_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sh_valid,
  input  logic [DW-1:0]    sh_word,
  input  logic             rd_req,
  output logic [DW-1:0]    rd_word,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ctl_int_en,
  input  logic [CNT_W-1:0] ctl_level,
  input  logic             ctl_ovf_clr,
  input  logic             ctl_int_clr,
  output logic             cfg_run,
  output logic             cfg_int_en,
  output logic [CNT_W-1:0] cfg_level,
  output logic [CNT_W-1:0] occupancy,
  output logic             ovf_flag,
  output logic             int_flag,
  output logic             irq
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Internal events, named for the assertions
  logic          ev_ovf_clr, ev_int_clr, ev_overrun, ev_write, ev_read;
  logic [PW-1:0] wr_ptr, rd_ptr;

  rxq_ctl #(.CNT_W(CNT_W), .RUN_RST(RUN_RST)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we),
    .wr_run(ctl_run), .wr_int_en(ctl_int_en), .wr_level(ctl_level),
    .wr_ovf_clr(ctl_ovf_clr), .wr_int_clr(ctl_int_clr),
    .run_q(cfg_run), .int_en_q(cfg_int_en), .level_q(cfg_level),
    .ovf_clr(ev_ovf_clr), .int_clr(ev_int_clr)
  );

  rxq_ptrs #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PW(PW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .push(sh_valid), .pop(rd_req),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(occupancy),
    .wr_en(ev_write), .rd_take(ev_read), .overrun(ev_overrun)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_write), .wr_ptr(wr_ptr),
    .wr_data(sh_word), .rd_take(ev_read), .rd_ptr(rd_ptr), .rd_data(rd_word)
  );

  rxq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(occupancy), .level(cfg_level),
    .overrun(ev_overrun), .ovf_clr(ev_ovf_clr), .int_clr(ev_int_clr),
    .int_en(cfg_int_en), .ovf_flag(ovf_flag), .int_flag(int_flag), .irq(irq)
  );

  // R6: a request never leaves without the enable
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_int_en && $stable(cfg_int_en)) |-> !irq);
  // R8: a full read-and-write is never a drop
  a_r8_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |-> !ev_overrun);

endmodule

// File: tb/sim_spi_rxq_top.sv
module sim_spi_rxq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sh_valid = 1'b0, rd_req = 1'b0, ctl_we = 1'b0;
  logic [15:0] sh_word = '0;
  logic        ctl_run = 1'b1, ctl_int_en = 1'b0, ctl_ovf_clr = 1'b0, ctl_int_clr = 1'b0;
  logic [4:0]  ctl_level = 5'h1f;
  logic [15:0] rd_word;
  logic        cfg_run, cfg_int_en, ovf_flag, int_flag, irq;
  logic [4:0]  cfg_level, occupancy;

  always #4 clk = ~clk;

  spi_rxq_top u0 (
    .clk(clk), .rst_n(rst_n), .sh_valid(sh_valid), .sh_word(sh_word),
    .rd_req(rd_req), .rd_word(rd_word), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .ctl_int_en(ctl_int_en), .ctl_level(ctl_level), .ctl_ovf_clr(ctl_ovf_clr),
    .ctl_int_clr(ctl_int_clr), .cfg_run(cfg_run), .cfg_int_en(cfg_int_en),
    .cfg_level(cfg_level), .occupancy(occupancy), .ovf_flag(ovf_flag),
    .int_flag(int_flag), .irq(irq)
  );

  int    total = 0, fails = 0;
  bit    done = 1'b0;
  string cur_req = "R7";

  // Reference model state
  logic [15:0] mq[$];
  bit          m_ovf = 0, m_int = 0, m_run = 1, m_en = 0;
  int          m_lvl = 31;
  logic [15:0] m_rd = '0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic bit thr_hit(input int cnt, input int lvl);
    return cnt >= lvl;
  endfunction

  // One edge of the model, from the values present before the edge.
  task automatic model_edge(input bit push, input logic [15:0] d, input bit pop,
                            input bit we, input bit run, input bit en, input int lvl,
                            input bit oc, input bit ic);
    bit dropped = 0;
    bit hit = thr_hit(mq.size(), m_lvl);
    if (m_run) begin
      if (pop && mq.size() > 0) m_rd = mq.pop_front();
      if (push) begin
        if (mq.size() == 4) begin
          void'(mq.pop_front());
          dropped = 1;
        end
        mq.push_back(d);
      end
    end else begin
      mq.delete();
    end
    if (dropped) m_ovf = 1; else if (we && oc) m_ovf = 0;
    if (hit) m_int = 1; else if (we && ic) m_int = 0;
    if (we) begin
      m_run = run; m_en = en; m_lvl = lvl;
    end
  endtask

  task automatic compare_all();
    chk("occupancy (R1)", 32'(occupancy), 32'(mq.size()));
    chk("ovf_flag (R3)", 32'(ovf_flag), 32'(m_ovf));
    chk("int_flag (R5)", 32'(int_flag), 32'(m_int));
    chk("irq (R6)", 32'(irq), 32'(m_int & m_en));
    chk("rd_word (R10)", 32'(rd_word), 32'(m_rd));
    chk("cfg_run (R4)", 32'(cfg_run), 32'(m_run));
    chk("cfg_level (R5)", 32'(cfg_level), 32'(m_lvl));
  endtask

  task automatic step(input bit push, input logic [15:0] d, input bit pop,
                      input bit we, input bit run, input bit en, input int lvl,
                      input bit oc, input bit ic);
    sh_valid = push; sh_word = d; rd_req = pop;
    ctl_we = we; ctl_run = run; ctl_int_en = en; ctl_level = 5'(lvl);
    ctl_ovf_clr = oc; ctl_int_clr = ic;
    @(posedge clk);
    model_edge(push, d, pop, we, run, en, lvl, oc, ic);
    @(negedge clk);
    compare_all();
  endtask

  task automatic xfer(input bit push, input logic [15:0] d, input bit pop);
    step(push, d, pop, 1'b0, 1'b1, 1'b0, 31, 1'b0, 1'b0);
  endtask

  task automatic ctl(input bit run, input bit en, input int lvl, input bit oc, input bit ic);
    step(1'b0, 16'h0, 1'b0, 1'b1, run, en, lvl, oc, ic);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset values
    cur_req = "R7";
    chk("cfg_level reset R7", 32'(cfg_level), 32'h1f);
    chk("cfg_int_en reset R7", 32'(cfg_int_en), 0);
    chk("cfg_run reset R7", 32'(cfg_run), 1);
    compare_all();
    // R7: fill with the reset threshold, no interrupt
    for (int i = 0; i < 4; i++) xfer(1, 16'hA000 + 16'(i), 0);
    repeat (2) xfer(0, 0, 0);
    chk("int_flag after fill R7", 32'(int_flag), 0);

    // R2: drop of the oldest word on a full queue
    cur_req = "R2";
    xfer(1, 16'hA004, 0);
    chk("occupancy after drop R2", 32'(occupancy), 4);
    chk("ovf_flag after drop R2", 32'(ovf_flag), 1);
    xfer(0, 0, 1);
    chk("first word after drop R2", 32'(rd_word), 32'hA001);

    // R3: write 0 keeps, write 1 clears, drop at the clear edge wins
    cur_req = "R3";
    ctl(1, 0, 31, 0, 0);
    chk("ovf kept by zero write R3", 32'(ovf_flag), 1);
    ctl(1, 0, 31, 1, 0);
    chk("ovf cleared R3", 32'(ovf_flag), 0);
    xfer(1, 16'hB000, 0);
    step(1, 16'hB001, 0, 1, 1, 0, 31, 1, 0);
    chk("ovf set beats clear R3", 32'(ovf_flag), 1);
    ctl(1, 0, 31, 1, 0);

    // R8: read and write together when full
    cur_req = "R8";
    xfer(1, 16'hC000, 1);
    chk("occupancy full swap R8", 32'(occupancy), 4);
    chk("no drop on full swap R8", 32'(ovf_flag), 0);

    // R1 and R10: drain in order
    cur_req = "R1";
    for (int i = 0; i < 4; i++) xfer(0, 0, 1);
    chk("drained R1", 32'(occupancy), 0);

    // R9: read on empty
    cur_req = "R9";
    xfer(0, 0, 1);
    chk("empty read keeps data R9", 32'(rd_word), 32'hC000);
    chk("empty read count R9", 32'(occupancy), 0);
    xfer(1, 16'hD000, 1);
    chk("push with empty read R9", 32'(occupancy), 1);

    // R4: hold empties and ignores words
    cur_req = "R4";
    xfer(1, 16'hD001, 0);
    ctl(0, 0, 31, 0, 0);
    xfer(1, 16'hD002, 0);
    chk("held queue empty R4", 32'(occupancy), 0);
    xfer(1, 16'hD003, 1);
    chk("held ignores words R4", 32'(occupancy), 0);
    ctl(1, 0, 31, 0, 0);
    xfer(1, 16'hD004, 0);
    xfer(0, 0, 1);
    chk("resumed from empty R4", 32'(rd_word), 32'hD004);

    // R5 and R6: threshold, mask, clear priority
    cur_req = "R5";
    ctl(1, 0, 2, 0, 0);
    for (int i = 0; i < 3; i++) xfer(1, 16'hE000 + 16'(i), 0);
    chk("int set at level R5", 32'(int_flag), 1);
    cur_req = "R6";
    chk("masked irq R6", 32'(irq), 0);
    ctl(1, 1, 2, 0, 0);
    chk("unmasked irq R6", 32'(irq), 1);
    cur_req = "R5";
    ctl(1, 1, 2, 0, 1);
    chk("clear loses to condition R5", 32'(int_flag), 1);
    xfer(0, 0, 1);
    xfer(0, 0, 1);
    step(0, 0, 0, 1, 1, 1, 2, 0, 1);
    chk("clear after drain R5", 32'(int_flag), 0);
    chk("irq low after clear R6", 32'(irq), 0);

    // Random mix against the model
    cur_req = "R1";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      if (r < 6) begin
        int lv = ($urandom % 4 == 0) ? 31 : int'($urandom % 6);
        step(0, 0, 0, 1, ($urandom % 8) != 0, $urandom % 2 == 1, lv,
             $urandom % 2 == 1, $urandom % 2 == 1);
      end else begin
        step($urandom % 100 < 50, 16'($urandom), $urandom % 100 < 42,
             0, 1, 0, 31, 0, 0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule